// File: doc/BRIEF.md
# Watchdog Timer with Quarter-Point Warning

This block is a supervision counter. It advances on count pulses from one of three low-rate time bases, chosen by a select field. Software must restart it with a clear strobe before it reaches a power-of-two limit. If software does not, the block raises a single-cycle reset request and starts a new period by itself.

An optional warning interrupt can be raised earlier in the period, at one, two or three quarters of the limit. Software can use it to wake up and service the timer. The warning stays set until software acknowledges it.

Counting can be suspended in three situations:
- while a debugger holds the processor, unless the debug-run bit is set;
- in deep sleep, unless that mode's run bit is set;
- in stop, unless that mode's run bit is set.

In hibernate, counting is always suspended. After any suspension the count carries on from the value it held. Dropping the enable bit returns the whole block to its idle condition.

Control is a small finite-state machine with three states:
- **IDLE**: disabled, with the counter held at zero.
- **ARMED**: counting, and the warning for this period has not yet been raised.
- **WARNED**: counting, and the warning for this period has been raised.

Its transitions are:
- **ENABLE**: IDLE to ARMED, when the enable bit is seen high.
- **WARN_HIT**: ARMED to WARNED, when a counted pulse lands on the warning point.
- **REARM**: WARNED to ARMED, on a clear strobe or on a timeout.
- **DISABLE**: any state to IDLE, when the enable bit is low.

The input clock `clk` is the fast system clock. Each time base reaches the block as a one-cycle pulse on its bit of `src_tick`.

Top module: `wdog_core`

## Requirements
- R1: After a clear strobe, or after the enable bit has been high for one cycle, `rst_req` rises in the clock cycle after the counted pulse numbered 2^(3+P)+1, where P is `cfg_period` (0 to 15). Earlier pulses leave it low.
- R2: `rst_req` is high for exactly one cycle. The count then restarts from zero, so the next timeout again needs 2^(3+P)+1 counted pulses.
- R3: `cfg_warn_sel` W selects the warning point. With W equal to 1, 2 or 3, `warn_irq` rises in the cycle after counted pulse number 2^(3+P)*W/4+1. With W equal to 0, no warning is raised.
- R4: `warn_irq` stays high until a `warn_clear` cycle. If a new warning and `warn_clear` arrive in the same cycle, the warning wins. At most one warning is raised per period, and the next warning is made possible by a clear strobe or a timeout.
- R5: Only pulses on `src_tick[cfg_src_sel]` are counted. Select value 3 names no source, so nothing is counted.
- R6: While `dbg_halt` is 1 and `cfg_dbg_run` is 0, pulses are not counted. Counting resumes from the held value when the halt ends.
- R7: `pwr_mode` encodes the power mode as 0 active, 1 sleep, 2 deep sleep, 3 stop, and 4 to 7 hibernate. The counter always runs in modes 0 and 1. It runs in mode 2 only if `cfg_deep_run` is 1, and in mode 3 only if `cfg_stop_run` is 1. It never runs in modes 4 to 7. A suspended count resumes where it stopped.
- R8: `kick` zeroes the count. A pulse in the same cycle as `kick` is not counted and cannot cause a timeout.
- R9: While `cfg_enable` is 0, both outputs are low in the next cycle, the count is zero, and pulses are ignored. A pulse in the first cycle after enable rises is not counted.
- R10: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | N_SRC | One-cycle count pulses, one bit per time base |
| cfg_enable | input | 1 | Enable; low returns the block to idle |
| cfg_src_sel | input | SEL_W | Time-base select |
| cfg_period | input | PER_W | Period exponent P |
| cfg_warn_sel | input | 2 | Warning quarter W, 0 = no warning |
| cfg_dbg_run | input | 1 | Keep counting during debug halt |
| cfg_deep_run | input | 1 | Keep counting in deep sleep |
| cfg_stop_run | input | 1 | Keep counting in stop |
| kick | input | 1 | Clear strobe |
| warn_clear | input | 1 | Acknowledge the warning |
| dbg_halt | input | 1 | Processor held by debugger |
| pwr_mode | input | 3 | Current power mode |
| warn_irq | output | 1 | Sticky warning interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Both outputs come from registers, so each result is due exactly one clock cycle after the counted pulse that causes it. The bench drives every pulse, strobe and mode change on a falling edge and holds it for one cycle. It samples on the next falling edge, where the effect of that single rising edge is already visible. Pulse numbers are counted in the bench and compared with limits computed from P and W. The single-cycle nature of `rst_req` is checked one further cycle later, with no pulse applied.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_ARMED  = 2'd1,
        WD_WARNED = 2'd2
    } wd_state_e;

    localparam logic [2:0] PM_ACTIVE = 3'd0;
    localparam logic [2:0] PM_SLEEP  = 3'd1;
    localparam logic [2:0] PM_DEEP   = 3'd2;
    localparam logic [2:0] PM_STOP   = 3'd3;

endpackage

// File: rtl/wdog_tick_gate.sv
module wdog_tick_gate #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             dbg_halt,
    input  logic             dbg_run,
    input  logic [2:0]       pwr_mode,
    input  logic             deep_run,
    input  logic             stop_run,
    output logic             tick_ok
);
    import wdog_pkg::*;

    logic [N_SRC-1:0] sel_hit;
    logic             tick_sel;
    logic             mode_run;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign sel_hit[i] = (src_sel == SEL_W'(i)) && src_tick[i];
    end

    assign tick_sel = |sel_hit;

    always_comb begin
        unique case (pwr_mode)
            PM_ACTIVE, PM_SLEEP: mode_run = 1'b1;
            PM_DEEP:             mode_run = deep_run;
            PM_STOP:             mode_run = stop_run;
            default:             mode_run = 1'b0;
        endcase
    end

    assign tick_ok = tick_sel && mode_run && !(dbg_halt && !dbg_run);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int PER_W = 4,
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [PER_W-1:0] period,
    input  logic [1:0]       warn_sel,
    output logic             at_limit,
    output logic             at_warn
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] warn_pt;

    always_comb begin
        limit   = CNT_W'(1) << (32'(period) + 32'd3);
        warn_pt = (limit >> 2) * CNT_W'(warn_sel);
    end

    assign at_limit = (cnt_q == limit);
    assign at_warn  = (warn_sel != 2'd0) && (cnt_q == warn_pt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2,
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             cfg_enable,
    input  logic [SEL_W-1:0] cfg_src_sel,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [1:0]       cfg_warn_sel,
    input  logic             cfg_dbg_run,
    input  logic             cfg_deep_run,
    input  logic             cfg_stop_run,
    input  logic             kick,
    input  logic             warn_clear,
    input  logic             dbg_halt,
    input  logic [2:0]       pwr_mode,
    output logic             warn_irq,
    output logic             rst_req
);
    import wdog_pkg::*;

    localparam int CNT_W = 3 + (2 ** PER_W);

    wd_state_e state_q, state_d;
    logic      tick_ok, adv, cnt_clr;
    logic      at_limit, at_warn;
    logic      tmo_evt, warn_evt;

    wdog_tick_gate #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_gate (
        .src_tick (src_tick),
        .src_sel  (cfg_src_sel),
        .dbg_halt (dbg_halt),
        .dbg_run  (cfg_dbg_run),
        .pwr_mode (pwr_mode),
        .deep_run (cfg_deep_run),
        .stop_run (cfg_stop_run),
        .tick_ok  (tick_ok)
    );

    assign adv     = cfg_enable && (state_q != WD_IDLE) && tick_ok;
    assign cnt_clr = !cfg_enable || kick || (state_q == WD_IDLE);

    wdog_count #(.PER_W(PER_W), .CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .adv      (adv),
        .period   (cfg_period),
        .warn_sel (cfg_warn_sel),
        .at_limit (at_limit),
        .at_warn  (at_warn)
    );

    assign tmo_evt  = adv && at_limit && !kick;
    assign warn_evt = (state_q == WD_ARMED) && adv && at_warn && !kick;

    always_comb begin
        state_d = state_q;
        if (!cfg_enable) begin
            state_d = WD_IDLE;
        end else begin
            unique case (state_q)
                WD_IDLE:   state_d = WD_ARMED;
                WD_ARMED:  if (warn_evt) state_d = WD_WARNED;
                WD_WARNED: if (kick || tmo_evt) state_d = WD_ARMED;
                default:   state_d = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            warn_irq <= 1'b0;
        end else if (!cfg_enable) begin
            rst_req  <= 1'b0;
            warn_irq <= 1'b0;
        end else begin
            rst_req <= tmo_evt;
            if (warn_evt)        warn_irq <= 1'b1;
            else if (warn_clear) warn_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter int N_SRC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_tick,
    input logic             cfg_enable,
    input logic             cfg_dbg_run,
    input logic             kick,
    input logic             warn_clear,
    input logic             dbg_halt,
    input logic [2:0]       pwr_mode,
    input logic             warn_irq,
    input logic             rst_req
);

    p_rst_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_warn_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_irq && !warn_clear && cfg_enable) |=> warn_irq);

    p_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_tick == '0) |=> !rst_req);

    p_debug_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !cfg_dbg_run) |=> !rst_req);

    p_hibernate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode >= 3'd4) |=> !rst_req);

    p_kick_no_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_req);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!rst_req && !warn_irq));

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (!rst_req && !warn_irq);
        end
    end

endmodule

bind wdog_core wdog_core_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_tick    (src_tick),
    .cfg_enable  (cfg_enable),
    .cfg_dbg_run (cfg_dbg_run),
    .kick        (kick),
    .warn_clear  (warn_clear),
    .dbg_halt    (dbg_halt),
    .pwr_mode    (pwr_mode),
    .warn_irq    (warn_irq),
    .rst_req     (rst_req)
);

// File: tb/wdog_core_test.sv
module wdog_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_tick = '0;
    logic       cfg_enable = 1'b0;
    logic [1:0] cfg_src_sel = '0;
    logic [3:0] cfg_period = '0;
    logic [1:0] cfg_warn_sel = '0;
    logic       cfg_dbg_run = 1'b0;
    logic       cfg_deep_run = 1'b0;
    logic       cfg_stop_run = 1'b0;
    logic       kick = 1'b0;
    logic       warn_clear = 1'b0;
    logic       dbg_halt = 1'b0;
    logic [2:0] pwr_mode = '0;
    logic       warn_irq, rst_req;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    wdog_core uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_enable(cfg_enable),
        .cfg_src_sel(cfg_src_sel), .cfg_period(cfg_period), .cfg_warn_sel(cfg_warn_sel),
        .cfg_dbg_run(cfg_dbg_run), .cfg_deep_run(cfg_deep_run), .cfg_stop_run(cfg_stop_run),
        .kick(kick), .warn_clear(warn_clear), .dbg_halt(dbg_halt), .pwr_mode(pwr_mode),
        .warn_irq(warn_irq), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int s);
        src_tick = '0;
        if (s < 3) src_tick[s] = 1'b1;
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic restart(input int p, input int w, input int sel);
        cfg_enable = 1'b0;
        idle(1);
        cfg_period   = 4'(p);
        cfg_warn_sel = 2'(w);
        cfg_src_sel  = 2'(sel);
        cfg_enable   = 1'b1;
        idle(1);
    endtask

    // counts pulses until rst_req; 0 means not seen
    task automatic measure(input int s, input int maxt, output int w_at,
                           output int r_at, output int drops);
        w_at = 0; r_at = 0; drops = 0;
        for (int i = 1; i <= maxt; i++) begin
            tick(s);
            if (warn_irq && w_at == 0) w_at = i;
            if (!warn_irq && w_at != 0) drops++;
            if (rst_req) begin
                r_at = i;
                break;
            end
        end
    endtask

    task automatic cond_trial(input string req, input bit dh, input logic [2:0] m,
                              input bit dr, input bit dp, input bit sr, input bit runs);
        int w, r, d, seen;
        cfg_dbg_run = dr; cfg_deep_run = dp; cfg_stop_run = sr;
        restart(0, 0, 0);
        repeat (4) tick(0);
        dbg_halt = dh; pwr_mode = m;
        seen = 0;
        repeat (4) begin
            tick(0);
            if (rst_req) seen++;
        end
        dbg_halt = 1'b0; pwr_mode = 3'd0;
        measure(0, 20, w, r, d);
        check({req, " held count resumes"}, r + seen, runs ? 1 : 5);
        cfg_dbg_run = 1'b0; cfg_deep_run = 1'b0; cfg_stop_run = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int w, r, d, seen, lim, wexp;
        idle(2);
        check("R10 warn_irq after reset", int'(warn_irq), 0);
        check("R10 rst_req after reset", int'(rst_req), 0);
        rst_n = 1'b1;
        idle(1);

        // R1 R2 R3 R4 sweep over period and warning select
        for (int p = 0; p <= 6; p++) begin
            for (int wsel = 0; wsel <= 3; wsel++) begin
                lim  = 1 << (3 + p);
                wexp = (wsel == 0) ? 0 : (lim * wsel / 4 + 1);
                restart(p, wsel, 0);
                measure(0, lim + 10, w, r, d);
                check($sformatf("R1 timeout P=%0d W=%0d", p, wsel), r, lim + 1);
                check($sformatf("R3 warning P=%0d W=%0d", p, wsel), w, wexp);
                check("R4 warning sticky", d, 0);
                idle(1);
                check("R2 single-cycle rst_req", int'(rst_req), 0);
                warn_clear = 1'b1; idle(1); warn_clear = 1'b0;
                check("R4 warn_clear drops flag", int'(warn_irq), 0);
                measure(0, lim + 10, w, r, d);
                check($sformatf("R2 second period P=%0d W=%0d", p, wsel), r, lim + 1);
                check($sformatf("R4 rearm after timeout P=%0d W=%0d", p, wsel), w, wexp);
            end
        end

        // R4 set beats clear, one warning per period
        restart(0, 1, 0);
        repeat (2) tick(0);
        warn_clear = 1'b1;
        tick(0);
        warn_clear = 1'b0;
        check("R4 warning wins over clear", int'(warn_irq), 1);
        warn_clear = 1'b1; idle(1); warn_clear = 1'b0;
        seen = 0;
        repeat (5) begin
            tick(0);
            if (warn_irq) seen++;
        end
        check("R4 single warning per period", seen, 0);

        // R5 source select
        restart(0, 0, 1);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            tick(0); if (rst_req) seen++;
            tick(2); if (rst_req) seen++;
        end
        check("R5 other sources ignored", seen, 0);
        measure(1, 20, w, r, d);
        check("R5 selected source 1 counted", r, 9);
        restart(0, 0, 3);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            for (int s = 0; s < 3; s++) begin
                tick(s); if (rst_req) seen++;
            end
        end
        check("R5 select 3 counts nothing", seen, 0);
        restart(0, 0, 2);
        measure(2, 20, w, r, d);
        check("R5 selected source 2 counted", r, 9);

        // R6 debug halt
        cond_trial("R6 halt frozen", 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        cond_trial("R6 halt with dbg_run", 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1);

        // R7 power modes
        cond_trial("R7 sleep runs", 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        cond_trial("R7 deep frozen", 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        cond_trial("R7 deep runs", 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1);
        cond_trial("R7 stop frozen", 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        cond_trial("R7 stop runs", 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        cond_trial("R7 hibernate frozen", 1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0);
        cond_trial("R7 mode 7 frozen", 1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0);

        // R8 kick
        restart(0, 0, 0);
        repeat (7) tick(0);
        kick = 1'b1; tick(0); kick = 1'b0;
        measure(0, 20, w, r, d);
        check("R8 kick zeroes count", r, 9);
        repeat (8) tick(0);
        kick = 1'b1; tick(0); kick = 1'b0;
        check("R8 kick beats timeout pulse", int'(rst_req), 0);
        measure(0, 20, w, r, d);
        check("R8 period after kick at limit", r, 9);

        // R9 disable
        restart(0, 1, 0);
        repeat (7) tick(0);
        check("R9 warning raised before disable", int'(warn_irq), 1);
        cfg_enable = 1'b0;
        idle(1);
        check("R9 warning cleared by disable", int'(warn_irq), 0);
        seen = 0;
        repeat (20) begin
            tick(0); if (rst_req || warn_irq) seen++;
        end
        check("R9 pulses ignored while disabled", seen, 0);
        cfg_enable = 1'b1;
        tick(0);
        measure(0, 20, w, r, d);
        check("R9 count restarts and enable-cycle pulse ignored", r, 9);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule